// File: doc/BRIEF.md
# USB Endpoint Control and Status Register Bank

This block holds the per-endpoint control and status flags of a small USB device controller: one control IN endpoint (endpoint 0) and four data endpoints (1 to 4), each with an IN register and an OUT register. The CPU reaches every flag through a byte-wide register bus with a write strobe and a combinational read. The serial interface engine reaches the same flags through single-cycle event pulses. It also receives single-cycle FIFO flush pulses from this block.

Every flag has a one-sided software write rule. A bit that software may only set ignores a written 0. A bit that software may only clear ignores a written 1. Because of this, firmware can change one flag with a plain full-byte store that carries the neutral value in every other flag position, and a flag that hardware raises during that store is not lost. While the USB bus-reset condition is present, every register in the endpoint window goes back to its reset value. The device, clock and synthesizer control registers outside the window keep their contents. Writes into the window are accepted only after the USB clock enable has been on for a set number of cycles.

Top module: `usb_ep_csr_bank`

## Requirements
- R1: After rst_ni every register reads 0, and unimplemented bit positions always read 0.
- R2: Endpoint 0 IN register (0x50): ready (bit 1) and data-end (bit 3) are set by writing 1, and writing 0 leaves them unchanged. Ready is cleared by ep0_in_done_i and data-end by ep0_status_done_i. A software set in the same cycle as the hardware clear wins.
- R3: Endpoint 0 stall flag (0x50 bit 4) is set by ep0_stall_sent_i and cleared by writing 0, and writing 1 leaves it unchanged. A hardware set beats a software clear in the same cycle.
- R4: Endpoint x IN register (0x50+x, x=1..4): ready (bit 0) is set-only from software and cleared by in_done_i[x-1]. Underrun (bit 1) is set by in_underrun_i[x-1] and is clear-only from software.
- R5: Endpoint x OUT register (0x54+x): ready (bit 0), overrun (bit 1), stall (bit 4) and data-error (bit 5) are set by out_pkt_i, out_overrun_i, out_stall_i and out_data_err_i. They are cleared by writing 0, and writing 1 leaves them unchanged. A hardware set wins over a same-cycle software clear.
- R6: Writing the neutral byte (0x10 to 0x50, 0x02 to an IN register, 0x33 to an OUT register) changes no flag.
- R7: Writing 1 to IN bit 6 gives a one-cycle in_flush_o pulse in the cycle after the write, and bit 6 reads 0. When the auto-flush enable (IN bit 7, plain read/write) is 1, each in_done_i pulse also gives a flush pulse one cycle later.
- R8: Writing 1 to OUT bit 6 gives a one-cycle out_flush_o pulse in the next cycle only if OUT ready was 1 before the write. Otherwise the write has no flush effect.
- R9: While usb_reset_i is 1, the window 0x50..0x5E reads its reset value, and writes and hardware events into it are ignored. 0x5A bit 0 reflects usb_reset_i. Registers 0x30 (device control), 0x31 (clock control) and 0x32 (synthesizer control) keep their values.
- R10: Writes to the window take effect only once clock-control bit 0 (USB clock enable) has read 1 for at least four cycles. Earlier window writes are dropped. Registers 0x30..0x32 are always writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for addr_i |
| usb_reset_i | input | 1 | USB bus-reset condition (level) |
| ep0_in_done_i | input | 1 | Endpoint 0 IN packet sent |
| ep0_status_done_i | input | 1 | Endpoint 0 status stage done |
| ep0_stall_sent_i | input | 1 | Endpoint 0 stall handshake sent |
| in_done_i | input | 4 | IN packet sent, endpoints 1..4 |
| in_underrun_i | input | 4 | IN underrun event, endpoints 1..4 |
| out_pkt_i | input | 4 | OUT packet received, endpoints 1..4 |
| out_overrun_i | input | 4 | OUT overrun event |
| out_stall_i | input | 4 | OUT stall handshake sent |
| out_data_err_i | input | 4 | OUT data error event |
| in_flush_o | output | 4 | IN FIFO flush pulses |
| out_flush_o | output | 4 | OUT FIFO flush pulses |

## Verification
Each flag is driven by its own pattern: a software set, a software clear, the neutral byte, a hardware event alone, and a hardware event in the same cycle as the opposing software write. Together these separate a missing write mask, an inverted write rule and a wrong collision priority. The flush paths are tried with ready both set and clear, and with auto-flush both on and off. Holding bus reset with flags raised and the outside registers loaded shows whether the clearing window is too narrow or too wide. A window write issued right after the clock enable is set, and another issued after the wait, check the gate's cycle count.

// File: rtl/usb_csr_pkg.sv
package usb_csr_pkg;
  localparam int unsigned AW        = 8;
  localparam int unsigned DW        = 8;
  localparam int unsigned N_EP      = 4;
  localparam int unsigned WAIT_CYC  = 4;

  localparam logic [AW-1:0] WIN_LO       = 8'h50;
  localparam logic [AW-1:0] WIN_HI       = 8'h5E;
  localparam logic [AW-1:0] A_EP0_IN     = 8'h50;
  localparam logic [AW-1:0] A_IN_BASE    = 8'h51;
  localparam logic [AW-1:0] A_OUT_BASE   = 8'h55;
  localparam logic [AW-1:0] A_STAT       = 8'h5A;
  localparam logic [AW-1:0] A_DEV_CTRL   = 8'h30;
  localparam logic [AW-1:0] A_CLK_CTRL   = 8'h31;
  localparam logic [AW-1:0] A_SYN_CTRL   = 8'h32;

  // bit positions decoded by firmware
  localparam int unsigned B_EP0_RDY   = 1;
  localparam int unsigned B_EP0_DEND  = 3;
  localparam int unsigned B_EP0_STALL = 4;
  localparam int unsigned B_IN_RDY    = 0;
  localparam int unsigned B_IN_URUN   = 1;
  localparam int unsigned B_FLUSH     = 6;
  localparam int unsigned B_IN_AUTO   = 7;
  localparam int unsigned B_OUT_RDY   = 0;
  localparam int unsigned B_OUT_OVR   = 1;
  localparam int unsigned B_OUT_STALL = 4;
  localparam int unsigned B_OUT_ERR   = 5;
endpackage

// File: rtl/usb_csr_wr_gate.sv
module usb_csr_wr_gate #(
  parameter int unsigned WAIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic wr_ok_o
);
  localparam int unsigned CW = $clog2(WAIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(WAIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign wr_ok_o = en_i && (cnt_q == CMAX);

  if (WAIT >= 4) begin : g_chk
    AST_GATE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_ok_o |-> ($past(en_i) && $past(en_i, 2) && $past(en_i, 3) && $past(en_i, 4))); // R10
  end
endmodule

// File: rtl/usb_csr_ep0_in.sv
module usb_csr_ep0_in
  import usb_csr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          in_done_i,
  input  logic          status_done_i,
  input  logic          stall_sent_i,
  output logic [DW-1:0] rdata_o
);
  logic rdy_q, dend_q, stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      dend_q  <= 1'b0;
      stall_q <= 1'b0;
    end else if (clr_i) begin
      rdy_q   <= 1'b0;
      dend_q  <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      // set-only from software; software set beats hardware clear
      if (wr_i && wdata_i[B_EP0_RDY])  rdy_q <= 1'b1;
      else if (in_done_i)              rdy_q <= 1'b0;
      if (wr_i && wdata_i[B_EP0_DEND]) dend_q <= 1'b1;
      else if (status_done_i)          dend_q <= 1'b0;
      // clear-only from software; hardware set wins
      if (stall_sent_i)                       stall_q <= 1'b1;
      else if (wr_i && !wdata_i[B_EP0_STALL]) stall_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[B_EP0_RDY]   = rdy_q;
    rdata_o[B_EP0_DEND]  = dend_q;
    rdata_o[B_EP0_STALL] = stall_q;
  end

  AST_EP0_STALL_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_q && !stall_sent_i) |=> !stall_q); // R3
  AST_EP0_RDY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && !in_done_i && !clr_i) |=> rdy_q); // R2
  AST_EP0_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rdata_o == '0)); // R9
endmodule

// File: rtl/usb_csr_in_ep.sv
module usb_csr_in_ep
  import usb_csr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          done_i,
  input  logic          underrun_i,
  output logic          flush_o,
  output logic [DW-1:0] rdata_o
);
  logic rdy_q, urun_q, auto_q, flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      urun_q  <= 1'b0;
      auto_q  <= 1'b0;
      flush_q <= 1'b0;
    end else if (clr_i) begin
      rdy_q   <= 1'b0;
      urun_q  <= 1'b0;
      auto_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (wr_i && wdata_i[B_IN_RDY]) rdy_q <= 1'b1;
      else if (done_i)               rdy_q <= 1'b0;
      if (underrun_i)                          urun_q <= 1'b1;
      else if (wr_i && !wdata_i[B_IN_URUN])    urun_q <= 1'b0;
      if (wr_i) auto_q <= wdata_i[B_IN_AUTO];
      flush_q <= (wr_i && wdata_i[B_FLUSH]) || (auto_q && done_i);
    end
  end

  assign flush_o = flush_q;

  always_comb begin
    rdata_o = '0;
    rdata_o[B_IN_RDY]  = rdy_q;
    rdata_o[B_IN_URUN] = urun_q;
    rdata_o[B_IN_AUTO] = auto_q;
  end

  AST_IN_URUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_i && !clr_i) |=> urun_q); // R4
  AST_IN_FLUSH_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(wr_i || done_i)); // R7
endmodule

// File: rtl/usb_csr_out_ep.sv
module usb_csr_out_ep
  import usb_csr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pkt_i,
  input  logic          overrun_i,
  input  logic          stall_i,
  input  logic          data_err_i,
  output logic          flush_o,
  output logic [DW-1:0] rdata_o
);
  logic rdy_q, ovr_q, stall_q, err_q, flush_q;

  function automatic logic clr_only(input logic cur, input logic hw_set,
                                    input logic wr, input logic wbit);
    if (hw_set)          return 1'b1;
    else if (wr && !wbit) return 1'b0;
    else                 return cur;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      ovr_q   <= 1'b0;
      stall_q <= 1'b0;
      err_q   <= 1'b0;
      flush_q <= 1'b0;
    end else if (clr_i) begin
      rdy_q   <= 1'b0;
      ovr_q   <= 1'b0;
      stall_q <= 1'b0;
      err_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      rdy_q   <= clr_only(rdy_q,   pkt_i,      wr_i, wdata_i[B_OUT_RDY]);
      ovr_q   <= clr_only(ovr_q,   overrun_i,  wr_i, wdata_i[B_OUT_OVR]);
      stall_q <= clr_only(stall_q, stall_i,    wr_i, wdata_i[B_OUT_STALL]);
      err_q   <= clr_only(err_q,   data_err_i, wr_i, wdata_i[B_OUT_ERR]);
      // flush honoured only with a packet present before the write
      flush_q <= wr_i && wdata_i[B_FLUSH] && rdy_q;
    end
  end

  assign flush_o = flush_q;

  always_comb begin
    rdata_o = '0;
    rdata_o[B_OUT_RDY]   = rdy_q;
    rdata_o[B_OUT_OVR]   = ovr_q;
    rdata_o[B_OUT_STALL] = stall_q;
    rdata_o[B_OUT_ERR]   = err_q;
  end

  AST_OUT_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_err_i && !clr_i) |=> err_q); // R5
  AST_OUT_FLUSH_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(rdy_q)); // R8
  AST_OUT_RDY_NO_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_q && !pkt_i) |=> !rdy_q); // R5
endmodule

// File: rtl/usb_ep_csr_bank.sv
module usb_ep_csr_bank
  import usb_csr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          we_i,
  output logic [7:0]    rdata_o,
  input  logic          usb_reset_i,
  input  logic          ep0_in_done_i,
  input  logic          ep0_status_done_i,
  input  logic          ep0_stall_sent_i,
  input  logic [3:0]    in_done_i,
  input  logic [3:0]    in_underrun_i,
  input  logic [3:0]    out_pkt_i,
  input  logic [3:0]    out_overrun_i,
  input  logic [3:0]    out_stall_i,
  input  logic [3:0]    out_data_err_i,
  output logic [3:0]    in_flush_o,
  output logic [3:0]    out_flush_o
);
  logic [DW-1:0] dev_q, clk_q, syn_q;
  logic          wr_ok, win_wr, ep0_wr;
  logic [DW-1:0] ep0_rd;
  logic [N_EP-1:0] in_wr, out_wr;
  logic [DW-1:0] in_rd  [N_EP];
  logic [DW-1:0] out_rd [N_EP];

  // registers outside the window: untouched by bus reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q <= '0;
      clk_q <= '0;
      syn_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_DEV_CTRL) dev_q <= wdata_i;
      if (addr_i == A_CLK_CTRL) clk_q <= wdata_i;
      if (addr_i == A_SYN_CTRL) syn_q <= wdata_i;
    end
  end

  usb_csr_wr_gate #(.WAIT(WAIT_CYC)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (clk_q[0]),
    .wr_ok_o (wr_ok)
  );

  assign win_wr = we_i && wr_ok && !usb_reset_i &&
                  (addr_i >= WIN_LO) && (addr_i <= WIN_HI);
  assign ep0_wr = win_wr && (addr_i == A_EP0_IN);

  usb_csr_ep0_in u_ep0 (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (usb_reset_i),
    .wr_i          (ep0_wr),
    .wdata_i       (wdata_i),
    .in_done_i     (ep0_in_done_i),
    .status_done_i (ep0_status_done_i),
    .stall_sent_i  (ep0_stall_sent_i),
    .rdata_o       (ep0_rd)
  );

  for (genvar i = 0; i < N_EP; i++) begin : g_ep
    assign in_wr[i]  = win_wr && (addr_i == A_IN_BASE  + AW'(i));
    assign out_wr[i] = win_wr && (addr_i == A_OUT_BASE + AW'(i));

    usb_csr_in_ep u_in (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (usb_reset_i),
      .wr_i       (in_wr[i]),
      .wdata_i    (wdata_i),
      .done_i     (in_done_i[i]),
      .underrun_i (in_underrun_i[i]),
      .flush_o    (in_flush_o[i]),
      .rdata_o    (in_rd[i])
    );

    usb_csr_out_ep u_out (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (usb_reset_i),
      .wr_i       (out_wr[i]),
      .wdata_i    (wdata_i),
      .pkt_i      (out_pkt_i[i]),
      .overrun_i  (out_overrun_i[i]),
      .stall_i    (out_stall_i[i]),
      .data_err_i (out_data_err_i[i]),
      .flush_o    (out_flush_o[i]),
      .rdata_o    (out_rd[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_EP0_IN)   rdata_o = ep0_rd;
    if (addr_i == A_STAT)     rdata_o = {7'd0, usb_reset_i};
    if (addr_i == A_DEV_CTRL) rdata_o = dev_q;
    if (addr_i == A_CLK_CTRL) rdata_o = clk_q;
    if (addr_i == A_SYN_CTRL) rdata_o = syn_q;
    for (int k = 0; k < N_EP; k++) begin
      if (addr_i == A_IN_BASE  + AW'(k)) rdata_o = in_rd[k];
      if (addr_i == A_OUT_BASE + AW'(k)) rdata_o = out_rd[k];
    end
  end

  AST_PERSIST_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (usb_reset_i && !we_i) |=> $stable(dev_q) && $stable(clk_q) && $stable(syn_q)); // R9
  AST_FLUSH_IDLE_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_reset_i |=> (in_flush_o == '0) && (out_flush_o == '0)); // R9
endmodule

// File: tb/usb_ep_csr_bank_bench.sv
module usb_ep_csr_bank_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] rdata_o;
  logic       usb_reset_i = 1'b0;
  logic       ep0_in_done_i = 1'b0, ep0_status_done_i = 1'b0, ep0_stall_sent_i = 1'b0;
  logic [3:0] in_done_i = '0, in_underrun_i = '0, out_pkt_i = '0;
  logic [3:0] out_overrun_i = '0, out_stall_i = '0, out_data_err_i = '0;
  logic [3:0] in_flush_o, out_flush_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  usb_ep_csr_bank u_usb_ep_csr_bank (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  // drive at negedge, edge occurs, return at next negedge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset;
    rd_chk("R1 ep0", 8'h50, 8'h00);
    for (int i = 0; i < 4; i++) begin
      rd_chk("R1 in", 8'h51 + 8'(i), 8'h00);
      rd_chk("R1 out", 8'h55 + 8'(i), 8'h00);
    end
    rd_chk("R1 clk", 8'h31, 8'h00);
  endtask

  task automatic t_gate;
    wr(8'h50, 8'h08);
    rd_chk("R10 before enable", 8'h50, 8'h00);
    wr(8'h31, 8'h01);
    wr(8'h50, 8'h08);
    rd_chk("R10 early write", 8'h50, 8'h00);
    rd_chk("R10 clk reg writable", 8'h31, 8'h01);
    idle(4);
    wr(8'h50, 8'h08);
    rd_chk("R10 after wait", 8'h50, 8'h08);
    ep0_status_done_i = 1'b1; @(negedge clk_i); ep0_status_done_i = 1'b0;
    rd_chk("R2 dend hw clear", 8'h50, 8'h00);
  endtask

  task automatic t_ep0;
    wr(8'h50, 8'h02);
    rd_chk("R2 rdy set", 8'h50, 8'h02);
    wr(8'h50, 8'h10);
    rd_chk("R6 ep0 neutral", 8'h50, 8'h02);
    ep0_in_done_i = 1'b1; @(negedge clk_i); ep0_in_done_i = 1'b0;
    rd_chk("R2 rdy hw clear", 8'h50, 8'h00);
    // software set collides with hardware clear
    ep0_in_done_i = 1'b1; wr(8'h50, 8'h12); ep0_in_done_i = 1'b0;
    rd_chk("R2 sw set wins", 8'h50, 8'h02);
    wr(8'h50, 8'h1A);
    rd_chk("R3 write1 no stall", 8'h50, 8'h0A);
    ep0_stall_sent_i = 1'b1; @(negedge clk_i); ep0_stall_sent_i = 1'b0;
    rd_chk("R3 stall set", 8'h50, 8'h1A);
    wr(8'h50, 8'h10);
    rd_chk("R6 ep0 neutral with stall", 8'h50, 8'h1A);
    ep0_stall_sent_i = 1'b1; wr(8'h50, 8'h00); ep0_stall_sent_i = 1'b0;
    rd_chk("R3 hw set wins", 8'h50, 8'h1A);
    wr(8'h50, 8'h00);
    rd_chk("R3 stall sw clear", 8'h50, 8'h0A);
    ep0_in_done_i = 1'b1; ep0_status_done_i = 1'b1; @(negedge clk_i);
    ep0_in_done_i = 1'b0; ep0_status_done_i = 1'b0;
    rd_chk("R2 both cleared", 8'h50, 8'h00);
  endtask

  task automatic t_in;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] a;
      a = 8'h51 + 8'(i);
      wr(a, 8'h03);
      rd_chk("R4 rdy set", a, 8'h01);
      in_underrun_i[i] = 1'b1; @(negedge clk_i); in_underrun_i[i] = 1'b0;
      rd_chk("R4 urun set", a, 8'h03);
      wr(a, 8'h02);
      rd_chk("R6 in neutral", a, 8'h03);
      in_underrun_i[i] = 1'b1; wr(a, 8'h00); in_underrun_i[i] = 1'b0;
      rd_chk("R4 hw set wins", a, 8'h03);
      wr(a, 8'h00);
      rd_chk("R4 urun sw clear", a, 8'h01);
      in_done_i[i] = 1'b1; @(negedge clk_i); in_done_i[i] = 1'b0;
      rd_chk("R4 rdy hw clear", a, 8'h00);
      chk("R7 no flush from done", {4'd0, in_flush_o}, 8'h00);
      wr(a, 8'h42);
      chk("R7 flush pulse", {4'd0, in_flush_o}, 8'(1 << i));
      rd_chk("R7 flush reads 0", a, 8'h00);
      @(negedge clk_i);
      chk("R7 flush one cycle", {4'd0, in_flush_o}, 8'h00);
      wr(a, 8'h82);
      in_done_i[i] = 1'b1; @(negedge clk_i); in_done_i[i] = 1'b0;
      chk("R7 auto flush", {4'd0, in_flush_o}, 8'(1 << i));
      wr(a, 8'h02);
      rd_chk("R7 auto off", a, 8'h00);
    end
  endtask

  task automatic t_out;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] a;
      a = 8'h55 + 8'(i);
      out_pkt_i[i] = 1'b1; out_overrun_i[i] = 1'b1; out_stall_i[i] = 1'b1; out_data_err_i[i] = 1'b1;
      @(negedge clk_i);
      out_pkt_i[i] = 1'b0; out_overrun_i[i] = 1'b0; out_stall_i[i] = 1'b0; out_data_err_i[i] = 1'b0;
      rd_chk("R5 all set", a, 8'h33);
      wr(a, 8'h33);
      rd_chk("R6 out neutral", a, 8'h33);
      wr(a, 8'h73);
      chk("R8 flush with rdy", {4'd0, out_flush_o}, 8'(1 << i));
      rd_chk("R8 flags kept", a, 8'h33);
      wr(a, 8'h31);
      rd_chk("R5 ovr clear", a, 8'h31);
      out_data_err_i[i] = 1'b1; wr(a, 8'h01); out_data_err_i[i] = 1'b0;
      rd_chk("R5 hw set wins", a, 8'h21);
      wr(a, 8'h00);
      rd_chk("R5 all clear", a, 8'h00);
      wr(a, 8'h73);
      chk("R8 no flush without rdy", {4'd0, out_flush_o}, 8'h00);
      rd_chk("R5 write1 no set", a, 8'h00);
    end
  endtask

  task automatic t_usb_reset;
    wr(8'h30, 8'hA5);
    wr(8'h32, 8'h3C);
    wr(8'h50, 8'h0A);
    wr(8'h52, 8'h81);
    out_pkt_i = 4'hF; out_data_err_i = 4'h1; @(negedge clk_i); out_pkt_i = '0; out_data_err_i = '0;
    rd_chk("R9 pre ep0", 8'h50, 8'h0A);
    usb_reset_i = 1'b1;
    @(negedge clk_i);
    rd_chk("R9 status", 8'h5A, 8'h01);
    rd_chk("R9 ep0 cleared", 8'h50, 8'h00);
    rd_chk("R9 in cleared", 8'h52, 8'h00);
    rd_chk("R9 out cleared", 8'h55, 8'h00);
    wr(8'h51, 8'h01);
    out_pkt_i = 4'h2; @(negedge clk_i); out_pkt_i = '0;
    rd_chk("R9 write ignored", 8'h51, 8'h00);
    rd_chk("R9 event ignored", 8'h56, 8'h00);
    usb_reset_i = 1'b0;
    @(negedge clk_i);
    rd_chk("R9 status low", 8'h5A, 8'h00);
    rd_chk("R9 dev kept", 8'h30, 8'hA5);
    rd_chk("R9 clk kept", 8'h31, 8'h01);
    rd_chk("R9 syn kept", 8'h32, 8'h3C);
    wr(8'h50, 8'h02);
    rd_chk("R10 still enabled", 8'h50, 8'h02);
  endtask

  initial begin
    idle(2);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_gate();
    t_ep0();
    t_in();
    t_out();
    t_usb_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule